// File: doc/BRIEF.md
# Serial EEPROM Slave on a Two-Wire Bus

This block models a 1 KB byte-addressed non-volatile memory that sits on an I2C bus as a slave. Its clock is the chip's system clock. The SCL and SDA lines are sampled through synchronizers and decoded into start, stop and bit events. SDA is open-drain: the single output says when the block pulls the line low. A system integrator wires the pad's input to `sda_i` and uses `sda_oe_o` as the low-side enable.

A bus master reaches the memory through the usual transactions:

- **Byte write:** one data byte.
- **Page write:** several data bytes in one transaction.
- **Current-address read:** returns the byte at the internal address pointer.
- **Random read:** a write-direction address phase, then a repeated start and a read.
- **Sequential read:** keeps returning bytes for as long as the master acknowledges them.

The 10-bit address has two parts. The two high bits come from the device byte of a write-direction transfer. The low eight bits come from the word-address byte. One internal pointer serves reads and writes, but it steps differently for each: reads walk the whole array, while writes stay inside a 16-byte page.

Top module: `eep_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start; a rising SDA while SCL is high is a stop. A stop puts the block in idle with SDA released. A stop in the middle of a data byte leaves memory unchanged.
- R2: The device byte is acknowledged only when bits 7:4 are 1010 and bit 3 equals `dev_sel_i`. Any other device byte is left unacknowledged, and SDA stays released until the next start.
- R3: The block acknowledges each accepted device, word-address and write-data byte by holding SDA low through the ninth SCL clock.
- R4: The block changes its SDA drive only while SCL is low. Data bits are sent MSB first.
- R5: A write-direction device byte (bit 0 = 0) latches its bits 2:1 as the high address bits. The word-address byte that follows loads the pointer with {those two bits, word byte}.
- R6: Each acknowledged data byte is stored at the pointer. The pointer's low 4 bits then step and wrap within the 16-byte page, leaving the upper bits unchanged.
- R7: A read-direction device byte (bit 0 = 1) with no address phase returns the byte at the pointer at once. The pointer then holds that address plus one.
- R8: A random read (address phase, repeated start, read device byte) returns the byte at the loaded address.
- R9: After each master ACK the next byte is sent. The read address steps across the whole array and wraps from 1023 to 0.
- R10: A master NACK ends the read. The block then drives nothing, even if SCL keeps toggling, until the next start.
- R11: Reset releases SDA and clears the pointer to 0. Otherwise the pointer keeps its value across transactions.
- R12: The bits 2:1 of a read-direction device byte are ignored. A current-address read uses the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| dev_sel_i | input | 1 | Strap compared with device-byte bit 3 |
| sda_oe_o | output | 1 | 1 = pull SDA low |

## Verification
The bench targets four corner cases:

- **Page-write wrap:** it writes four bytes starting two bytes before a page end. A pointer that carried into the next page would overwrite a neighbour the bench reads back.
- **Sequential read across the array end:** a pointer that saturated or wrapped only within the page would return the wrong bytes after address 1023.
- **Ignored high bits on a read:** a current-address read whose device byte carries unrelated high bits would fetch from another quarter if those bits were not ignored.
- **Abandoned transfers:** a device byte with the wrong strap, a NACK followed by extra clocks, and a stop in the middle of a data byte. A block that kept driving SDA, or that stored a partial byte, shows up as a wrong ACK, a non-0xFF read, or a corrupted byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HI_W   = 2;
  localparam int unsigned ADDR_W = HI_W + BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } eep_state_e;

  // read pointer steps over the whole array
  function automatic logic [ADDR_W-1:0] rd_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  // write pointer steps inside a page of 2**pw bytes
  function automatic logic [ADDR_W-1:0] wr_step(input logic [ADDR_W-1:0] a,
                                               input int unsigned pw);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'((1 << pw) - 1);
    return (a & ~m) | ((a + 1'b1) & m);
  endfunction
endpackage

// File: rtl/eep_line_sense.sv
module eep_line_sense #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_N-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_N-2:0], scl_i};
      sda_q <= {sda_q[SYNC_N-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s    = scl_q[SYNC_N-1];
  assign sda_s    = sda_q[SYNC_N-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int unsigned AW = eep_pkg::ADDR_W,
  parameter int unsigned DW = eep_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int unsigned PAGE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [eep_pkg::ADDR_W-1:0] load_val,
  input  logic                      step_rd,
  input  logic                      step_wr,
  output logic [eep_pkg::ADDR_W-1:0] ctr
);
  import eep_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctr <= '0;
    else if (load)    ctr <= load_val;
    else if (step_wr) ctr <= wr_step(ctr, PAGE_W);
    else if (step_rd) ctr <= rd_step(ctr);
  end

  // R6: a write step never leaves the page
  p_wr_page_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_wr && !load) |=> ctr[ADDR_W-1:PAGE_W] == $past(ctr[ADDR_W-1:PAGE_W]));

  // R9: a read step from the top address returns to zero
  p_rd_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rd && !load && !step_wr && (&ctr)) |=> ctr == '0);
endmodule

// File: rtl/eep_slave.sv
module eep_slave #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic dev_sel_i,
  output logic sda_oe_o
);
  import eep_pkg::*;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  eep_line_sense #(.SYNC_N(SYNC_N)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eep_state_e        state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic [HI_W-1:0]   hi_bits;
  logic              rd_dir, mst_ack, sda_oe;

  // named internal events
  logic              byte_done, dev_match, wa_load, wr_commit, rd_load;
  logic [ADDR_W-1:0] ptr, ptr_load_val;
  logic [BYTE_W-1:0] rd_byte;

  assign byte_done    = (bitcnt == BITS_PER_BYTE);
  assign dev_match    = (rx_sh[7:4] == DEV_TYPE) && (rx_sh[3] == dev_sel_i);
  assign wa_load      = (state == ST_WADDR) && scl_fall && byte_done;
  assign wr_commit    = (state == ST_WDATA) && scl_fall && byte_done;
  assign rd_load      = scl_fall &&
                        (((state == ST_DEV_ACK) && rd_dir) ||
                         ((state == ST_RACK) && mst_ack));
  assign ptr_load_val = {hi_bits, rx_sh};

  eep_addr_ctr #(.PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(wa_load), .load_val(ptr_load_val),
    .step_rd(rd_load), .step_wr(wr_commit), .ctr(ptr)
  );

  eep_store #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(wr_commit), .addr(ptr), .wdata(rx_sh), .rdata(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      hi_bits <= '0;
      rd_dir  <= 1'b0;
      mst_ack <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && !byte_done) begin
            rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && byte_done) begin
            bitcnt <= '0;
            if (state == ST_DEV) begin
              if (dev_match) begin
                state  <= ST_DEV_ACK;
                sda_oe <= 1'b1;
                rd_dir <= rx_sh[0];
                if (!rx_sh[0]) hi_bits <= rx_sh[2:1];
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              state  <= ST_WADDR_ACK;
              sda_oe <= 1'b1;
            end else begin
              state  <= ST_WDATA_ACK;
              sda_oe <= 1'b1;
            end
          end
        end
        ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if ((state == ST_DEV_ACK) && rd_dir) begin
              state  <= ST_RDATA;
              tx_sh  <= rd_byte;
              sda_oe <= ~rd_byte[BYTE_W-1];
            end else begin
              state  <= (state == ST_DEV_ACK) ? ST_WADDR : ST_WDATA;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (byte_done) begin
              state  <= ST_RACK;
              sda_oe <= 1'b0;
            end else begin
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_sh[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (mst_ack) begin
              state  <= ST_RDATA;
              tx_sh  <= rd_byte;
              sda_oe <= ~rd_byte[BYTE_W-1];
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  assign sda_oe_o = sda_oe;

  // R1: a stop sends the block to idle with SDA released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE) && !sda_oe);

  // R2: an idle block never drives the line
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R3: a completed write-data byte is acknowledged
  p_ack_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> sda_oe && (state == ST_WDATA_ACK));

  // R4: the drive only moves while SCL is low
  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R10: a master NACK ends the read
  p_nack_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RACK) && scl_fall && !mst_ack) |=> (state == ST_IDLE) && !sda_oe);
endmodule

// File: tb/eep_slave_test.sv
module eep_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8 * CLK_PERIOD;
  localparam int NVEC = 8;
  // {address, data}
  localparam logic [17:0] VEC [NVEC] = '{
    {10'h000, 8'hA5}, {10'h001, 8'h3C}, {10'h130, 8'h55}, {10'h0FF, 8'h81},
    {10'h100, 8'h7E}, {10'h2C4, 8'hD2}, {10'h3FD, 8'h19}, {10'h21A, 8'hE7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   n_chk = 0;
  int   n_fail = 0;
  int   r4_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eep_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(1'b1), .sda_oe_o(sda_oe)
  );

  // R4 monitor: the drive may move only while SCL is low
  always @(sda_oe) if (rst_n && scl_m) r4_bad++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devb(input logic [1:0] p, input logic rd);
    return {4'b1010, 1'b1, p, rd};
  endfunction

  task automatic send_bit(input logic b);
    #(Q) sda_m = b;
    #(Q) scl_m = 1'b1;
    #(Q);
    #(Q) scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    #(Q) sda_m = 1'b1;
    #(Q) scl_m = 1'b1;
    #(Q) ack = ~sda_line;
    #(Q) scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      #(Q) sda_m = 1'b1;
      #(Q) scl_m = 1'b1;
      #(Q) d = {d[6:0], sda_line};
      #(Q) scl_m = 1'b0;
    end
    #(Q) sda_m = give_ack ? 1'b0 : 1'b1;
    #(Q) scl_m = 1'b1;
    #(Q);
    #(Q) scl_m = 1'b0;
  endtask

  task automatic bus_start();
    #(Q) sda_m = 1'b1;
    #(Q) scl_m = 1'b1;
    #(Q) sda_m = 1'b0;
    #(Q) scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    #(Q) sda_m = 1'b0;
    #(Q) scl_m = 1'b1;
    #(Q) sda_m = 1'b1;
    #(Q);
  endtask

  task automatic put(input logic [7:0] d, input string tag);
    logic a;
    send_byte(d, a);
    chk(tag, a, 1);
  endtask

  task automatic addr_phase(input logic [9:0] a);
    bus_start();
    put(devb(a[9:8], 1'b0), "R3 dev ack");
    put(a[7:0], "R3 word addr ack");
  endtask

  task automatic byte_write(input logic [9:0] a, input logic [7:0] d);
    addr_phase(a);
    put(d, "R6 data ack");
    bus_stop();
  endtask

  task automatic rand_read_begin(input logic [9:0] a);
    addr_phase(a);
    bus_start();
    put(devb(a[9:8], 1'b1), "R8 read dev ack");
  endtask

  task automatic get(input logic give_ack, input int exp, input string tag);
    logic [7:0] d;
    recv_byte(give_ack, d);
    chk(tag, d, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a;
    #2;
    #(CLK_PERIOD * 5);
    chk("R11 reset drive", sda_oe, 0);
    rst_n = 1'b1;
    #(CLK_PERIOD * 5);

    // table: byte writes then random reads back
    for (int i = 0; i < NVEC; i++) byte_write(VEC[i][17:8], VEC[i][7:0]);
    for (int i = 0; i < NVEC; i++) begin
      rand_read_begin(VEC[i][17:8]);
      get(1'b0, VEC[i][7:0], "R8 R5 random read");
      bus_stop();
    end

    // R11: reset clears the pointer, memory keeps contents
    rst_n = 1'b0;
    #(CLK_PERIOD * 4);
    rst_n = 1'b1;
    #(CLK_PERIOD * 4);
    bus_start();
    put(devb(2'b00, 1'b1), "R7 cur dev ack");
    get(1'b0, 8'hA5, "R11 pointer zero after reset");
    bus_stop();
    bus_start();
    put(devb(2'b00, 1'b1), "R7 cur dev ack");
    get(1'b0, 8'h3C, "R7 pointer persists plus one");
    bus_stop();

    // R2: wrong type and wrong strap are ignored
    bus_start();
    send_byte({4'b1011, 1'b1, 2'b00, 1'b0}, a);
    chk("R2 wrong type no ack", a, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1010, 1'b0, 2'b00, 1'b0}, a);
    chk("R2 wrong strap no ack", a, 0);
    send_byte(8'h00, a);
    chk("R2 silent after mismatch", a, 0);
    bus_stop();

    // R6: page write wrapping inside the page
    addr_phase(10'h12E);
    put(8'h11, "R6 page ack");
    put(8'h22, "R6 page ack");
    put(8'h33, "R6 page ack");
    put(8'h44, "R6 page ack");
    bus_stop();
    rand_read_begin(10'h12E);
    get(1'b1, 8'h11, "R6 page byte 12E");
    get(1'b0, 8'h22, "R6 page byte 12F");
    bus_stop();
    rand_read_begin(10'h120);
    get(1'b1, 8'h33, "R6 wrapped byte 120");
    get(1'b0, 8'h44, "R6 wrapped byte 121");
    bus_stop();
    rand_read_begin(10'h130);
    get(1'b0, 8'h55, "R6 next page untouched");
    bus_stop();

    // R9: sequential read across the array end
    byte_write(10'h3FE, 8'h6A);
    byte_write(10'h3FF, 8'h9B);
    rand_read_begin(10'h3FE);
    get(1'b1, 8'h6A, "R9 seq 3FE");
    get(1'b1, 8'h9B, "R9 seq 3FF");
    get(1'b1, 8'hA5, "R9 seq wrap 000");
    get(1'b0, 8'h3C, "R9 seq 001");
    bus_stop();

    // R12: read device byte high bits ignored
    rand_read_begin(10'h0FF);
    get(1'b0, 8'h81, "R8 read 0FF");
    bus_stop();
    bus_start();
    put(devb(2'b11, 1'b1), "R12 cur dev ack");
    get(1'b0, 8'h7E, "R12 pointer kept high bits");
    bus_stop();

    // R10: after NACK the block stays off the line
    rand_read_begin(10'h2C4);
    get(1'b0, 8'hD2, "R10 last byte");
    get(1'b0, 8'hFF, "R10 no drive after nack");
    bus_stop();

    // R1: stop inside a data byte stores nothing
    addr_phase(10'h21A);
    send_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b0);
    bus_stop();
    chk("R1 released after stop", sda_oe, 0);
    rand_read_begin(10'h21A);
    get(1'b0, 8'hE7, "R1 aborted byte not stored");
    bus_stop();

    chk("R4 drive moves only with SCL low", r4_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule